// File: doc/BRIEF.md
# Text and Graphics Pixel Formatter

The formatter turns 16-bit display words into a stream of 4-bit RGBI pixels. Each word is captured on a load strobe. The low byte becomes the character code and the high byte the attribute. At the same moment the mode and the current scanline index are captured. The captured character and scanline form the address of an external glyph ROM. The ROM answers combinationally with an 8-bit glyph row.

On the next load strobe, the stored data moves into an output shifter while a new word is captured. The shifter's content depends on the mode:

- In text mode, the shifter takes the glyph row. Each glyph bit picks the foreground or the background nibble of the attribute.
- In the two graphics modes, the glyph path is bypassed and the stored bits are unpacked directly as pixels.

One pixel leaves per pixel-clock enable. The pixel that follows a load comes from the new word, so no pixel slot is lost at the group boundary. A blanking input forces the output to zero.

Top module: `pxf_pixel_formatter`

## Requirements
- R1: While reset is held, and after it is released with no pixel enable, `pix_o` is 0 and `rom_addr_o` is 0.
- R2: On a clock edge where `pix_en_i` and `load_i` are both high, the block captures `word_i[7:0]` as character, `word_i[15:8]` as attribute, `row_i` and `mode_i`. From that edge on, `rom_addr_o` equals `{character, row}`. A `load_i` pulse without `pix_en_i` captures nothing.
- R3: Text mode (mode 2'b00) shifts out the glyph row MSB first. A glyph bit of 1 emits attribute bits 3:0 (foreground) and a glyph bit of 0 emits attribute bits 7:4 (background).
- R4: Four-colour mode (mode 2'b01) emits 2 bits per pixel, taking word bits 15:14 first and 1:0 last. The output is `{2'b00, value}`.
- R5: Two-colour mode (mode 2'b10 or 2'b11) emits word bits 7:0 MSB first. A 1 gives 4'hF and a 0 gives 4'h0.
- R6: The word captured at one load strobe is shown in the eight enabled pixels that start at the following load strobe. Its first pixel appears on `pix_o` right after that load edge, with no gap.
- R7: On edges where `pix_en_i` is low, `pix_o` and the shift position hold.
- R8: A pixel emitted on an edge with `blank_i` high is 0, and the shifter still advances past that pixel.
- R9: Changes to `mode_i`, `row_i` and `word_i` between load strobes have no effect on the pixels being emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_en_i | input | 1 | Pixel clock enable; one pixel per enabled edge |
| load_i | input | 1 | Word load strobe, qualified by `pix_en_i`, every 8 pixels |
| word_i | input | 16 | Fetched display word: {attribute, character} |
| mode_i | input | 2 | 00 text, 01 four-colour, 1x two-colour |
| row_i | input | 4 | Scanline index within the character cell |
| blank_i | input | 1 | Forces the emitted pixel to 0 |
| rom_addr_o | output | 12 | Glyph ROM address {character, row} |
| rom_data_i | input | 8 | Glyph row returned by the ROM, MSB is leftmost pixel |
| pix_o | output | 4 | RGBI pixel |

## Verification
`pix_o` is a register, so each pixel is due right after the enabled edge that emits it. Pixel 0 of a word comes one load strobe after the word was captured. Pixel n of that word follows n enabled edges later, however many idle cycles are inserted between them.

`rom_addr_o` is valid after the capturing edge and is checked at the next falling edge.

The driver computes each expected pixel when it drives the edge that will produce it, and queues that value. The monitor samples 2 ns after every rising edge. On an enabled edge it pops and compares one entry. On a disabled edge it checks that the previous value held.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
  typedef enum logic [1:0] {
    MODE_TEXT = 2'b00,
    MODE_GFX4 = 2'b01,
    MODE_GFX2 = 2'b10,
    MODE_GFX2B = 2'b11
  } pxf_mode_e;

  function automatic logic is_text(input logic [1:0] m);
    return m == MODE_TEXT;
  endfunction

  function automatic logic is_gfx4(input logic [1:0] m);
    return m == MODE_GFX4;
  endfunction
endpackage

// File: rtl/pxf_fetch_latch.sv
module pxf_fetch_latch #(
  parameter int BYTE_W = 8,
  parameter int ROW_W  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_i,
  input  logic [2*BYTE_W-1:0]   word_i,
  input  logic [ROW_W-1:0]      row_i,
  input  logic [1:0]            mode_i,
  output logic [BYTE_W-1:0]     char_o,
  output logic [BYTE_W-1:0]     attr_o,
  output logic [ROW_W-1:0]      row_o,
  output logic [1:0]            mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_o <= '0;
      attr_o <= '0;
      row_o  <= '0;
      mode_o <= '0;
    end else if (cap_i) begin
      char_o <= word_i[BYTE_W-1:0];
      attr_o <= word_i[2*BYTE_W-1:BYTE_W];
      row_o  <= row_i;
      mode_o <= mode_i;
    end
  end

  // R2
  char_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> char_o == $past(word_i[BYTE_W-1:0]) && row_o == $past(row_i));

  // R9
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(char_o) && $stable(attr_o) && $stable(mode_o));
endmodule

// File: rtl/pxf_shifter.sv
module pxf_shifter
  import pxf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] char_i,
  input  logic [BYTE_W-1:0] attr_i,
  input  logic [1:0]        mode_i,
  input  logic [BYTE_W-1:0] glyph_i,
  output logic [1:0]        bits_o,
  output logic [BYTE_W-1:0] attr_o,
  output logic [1:0]        mode_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] sh_q, src, nxt;
  logic [BYTE_W-1:0] attr_q;
  logic [1:0]        mode_q;

  // On a load the first pixel is taken from the incoming data, not the stale shifter
  always_comb begin
    if (load_i) begin
      mode_o = mode_i;
      attr_o = attr_i;
      if (is_gfx4(mode_i))      src = {attr_i, char_i};
      else if (is_text(mode_i)) src = {glyph_i, {BYTE_W{1'b0}}};
      else                      src = {char_i, {BYTE_W{1'b0}}};
    end else begin
      mode_o = mode_q;
      attr_o = attr_q;
      src    = sh_q;
    end
    bits_o = src[WORD_W-1 -: 2];
    nxt    = is_gfx4(mode_o) ? (src << 2) : (src << 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      attr_q <= '0;
      mode_q <= '0;
    end else begin
      if (adv_i) sh_q <= nxt;
      if (load_i) begin
        attr_q <= attr_i;
        mode_q <= mode_i;
      end
    end
  end

  // R7
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(sh_q));

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mode_q) && $stable(attr_q));
endmodule

// File: rtl/pxf_color_mux.sv
module pxf_color_mux
  import pxf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adv_i,
  input  logic                blank_i,
  input  logic [1:0]          bits_i,
  input  logic [BYTE_W-1:0]   attr_i,
  input  logic [1:0]          mode_i,
  output logic [BYTE_W/2-1:0] pix_o
);
  localparam int CW = BYTE_W / 2;

  logic [CW-1:0] fg, bg, color;

  assign fg = attr_i[CW-1:0];
  assign bg = attr_i[BYTE_W-1:CW];

  always_comb begin
    if (is_text(mode_i))      color = bits_i[1] ? fg : bg;
    else if (is_gfx4(mode_i)) color = CW'(bits_i);
    else                      color = {CW{bits_i[1]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pix_o <= '0;
    else if (adv_i) pix_o <= blank_i ? '0 : color;
  end

  // R8
  blank_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && blank_i |=> pix_o == '0);

  // R7
  pix_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(pix_o));

  // R3
  text_fg_bg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !blank_i && is_text(mode_i) |=>
      pix_o == $past(attr_i[CW-1:0]) || pix_o == $past(attr_i[BYTE_W-1:CW]));

  // R5
  gfx2_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !blank_i && mode_i[1] |=> pix_o == '0 || pix_o == '1);

  // R4
  gfx4_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !blank_i && is_gfx4(mode_i) |=> pix_o[CW-1:2] == '0);
endmodule

// File: rtl/pxf_pixel_formatter.sv
module pxf_pixel_formatter #(
  parameter int BYTE_W = 8,
  parameter int ROW_W  = 4,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int ADDR_W = BYTE_W + ROW_W,
  localparam int CW     = BYTE_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_en_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        mode_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              blank_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [BYTE_W-1:0] rom_data_i,
  output logic [CW-1:0]     pix_o
);
  logic              cap;
  logic [BYTE_W-1:0] lat_char, lat_attr, cur_attr;
  logic [ROW_W-1:0]  lat_row;
  logic [1:0]        lat_mode, cur_mode, cur_bits;

  assign cap = pix_en_i & load_i;

  pxf_fetch_latch #(.BYTE_W(BYTE_W), .ROW_W(ROW_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .word_i (word_i),
    .row_i  (row_i),
    .mode_i (mode_i),
    .char_o (lat_char),
    .attr_o (lat_attr),
    .row_o  (lat_row),
    .mode_o (lat_mode)
  );

  assign rom_addr_o = {lat_char, lat_row};

  pxf_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (pix_en_i),
    .load_i  (cap),
    .char_i  (lat_char),
    .attr_i  (lat_attr),
    .mode_i  (lat_mode),
    .glyph_i (rom_data_i),
    .bits_o  (cur_bits),
    .attr_o  (cur_attr),
    .mode_o  (cur_mode)
  );

  pxf_color_mux #(.BYTE_W(BYTE_W)) u_color (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (pix_en_i),
    .blank_i (blank_i),
    .bits_i  (cur_bits),
    .attr_i  (cur_attr),
    .mode_i  (cur_mode),
    .pix_o   (pix_o)
  );

  // R2
  rom_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> $stable(rom_addr_o));
endmodule

// File: tb/pxf_pixel_formatter_tb.sv
module pxf_pixel_formatter_tb;
  logic        clk = 1'b0;
  logic        rst_n, pix_en, load, blank;
  logic [1:0]  mode;
  logic [3:0]  row;
  logic [15:0] word;
  logic [11:0] rom_addr;
  logic [7:0]  rom_data;
  logic [3:0]  pix;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] rom_f(input logic [11:0] a);
    return a[11:4] ^ {a[3:0], a[2:0], a[3]} ^ 8'h5A;
  endfunction

  assign rom_data = rom_f(rom_addr);

  pxf_pixel_formatter u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pix_en_i   (pix_en),
    .load_i     (load),
    .word_i     (word),
    .mode_i     (mode),
    .row_i      (row),
    .blank_i    (blank),
    .rom_addr_o (rom_addr),
    .rom_data_i (rom_data),
    .pix_o      (pix)
  );

  logic [3:0] exp_q[$];
  string      tag_q[$];

  // latch-stage and shift-stage model
  logic [15:0] m_word = '0, s_word = '0;
  logic [3:0]  m_row = '0, s_row = '0;
  logic [1:0]  m_mode = '0, s_mode = '0;
  int          s_idx = 0;
  bit          addr_pending = 0;
  logic [11:0] addr_exp;

  task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [3:0] exp_px(input logic [1:0] md, input logic [15:0] w,
                                         input logic [3:0] rw, input int idx);
    logic [7:0] g;
    logic [1:0] v;
    if (md == 2'b00) begin
      g = rom_f({w[7:0], rw});
      return g[7-idx] ? w[11:8] : w[15:12];
    end else if (md == 2'b01) begin
      v = w[15-2*idx -: 2];
      return {2'b00, v};
    end else begin
      return w[7-idx] ? 4'hF : 4'h0;
    end
  endfunction

  task automatic drive_pixel(input logic ld, input logic [15:0] w, input logic [1:0] md,
                             input logic [3:0] rw, input logic bl);
    logic [3:0] e;
    string t;
    @(negedge clk);
    if (addr_pending) begin
      // R2
      check(rom_addr == addr_exp, "R2", 16'(rom_addr), 16'(addr_exp));
      addr_pending = 0;
    end
    pix_en = 1'b1; load = ld; blank = bl; word = w; row = rw; mode = md;
    if (ld) begin
      s_word = m_word; s_row = m_row; s_mode = m_mode; s_idx = 0;
      m_word = w; m_row = rw; m_mode = md;
      addr_pending = 1; addr_exp = {w[7:0], rw};
    end
    e = bl ? 4'h0 : exp_px(s_mode, s_word, s_row, s_idx);
    t = bl ? "R8" : (s_mode == 2'b00 ? "R3" : (s_mode == 2'b01 ? "R4" : "R5"));
    t = ld ? {t, " R6"} : {t, " R9"};
    s_idx++;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      // R2: load without enable must be ignored
      pix_en = 1'b0; load = 1'b1; word = 16'hFFFF; mode = 2'b01; row = 4'hF; blank = 1'b0;
    end
  endtask

  task automatic group(input logic [15:0] w, input logic [1:0] md, input logic [3:0] rw,
                       input logic [7:0] bl_mask, input int gap);
    for (int i = 0; i < 8; i++) begin
      if (i == 0) drive_pixel(1'b1, w, md, rw, bl_mask[7]);
      else drive_pixel(1'b0, w ^ 16'hA5C3, md ^ 2'b01, rw + 4'd3, bl_mask[7-i]); // R9 scramble
      if (gap > 0 && i == 3) idle(gap);
    end
  endtask

  // monitor
  initial begin
    logic fired;
    logic [3:0] last = '0;
    logic [3:0] e;
    string t;
    forever begin
      @(posedge clk);
      fired = pix_en && rst_n;
      #2;
      if (!rst_n) continue;
      if (fired) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", 16'(pix), 16'hFFFF);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(pix == e, t, 16'(pix), 16'(e));
        end
        last = pix;
      end else begin
        // R7
        check(pix == last, "R7", 16'(pix), 16'(last));
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_en = 1'b0; load = 1'b0; blank = 1'b0;
    mode = 2'b00; row = '0; word = '0;
    repeat (3) @(negedge clk);
    // R1
    check(pix == 4'h0, "R1", 16'(pix), 16'h0);
    check(rom_addr == 12'h0, "R1", 16'(rom_addr), 16'h0);
    rst_n = 1'b1;
    idle(2);
    check(pix == 4'h0, "R1", 16'(pix), 16'h0);
    check(rom_addr == 12'h0, "R1", 16'(rom_addr), 16'h0);

    group(16'h1E41, 2'b00, 4'd0, 8'h00, 0);
    group(16'h7A30, 2'b00, 4'd5, 8'h00, 0);
    group(16'h4C8D, 2'b00, 4'd9, 8'b0011_1100, 0);
    group(16'hC3B6, 2'b01, 4'd2, 8'h00, 3);
    group(16'h1B2E, 2'b01, 4'd0, 8'h00, 0);
    group(16'h96A5, 2'b10, 4'd0, 8'h00, 2);
    group(16'h5A3C, 2'b11, 4'd1, 8'b1000_0001, 0);
    group(16'hF00F, 2'b00, 4'd15, 8'h00, 1);
    group(16'h0000, 2'b00, 4'd0, 8'h00, 0);
    idle(4);
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule